// File: doc/BRIEF.md
# Two-Processor Slotted Mailbox

This block lets two processors pass short messages to each other. Each processor owns one receive mailbox. A mailbox is a circular queue of fixed-length message slots kept in a small dedicated RAM, and a descriptor tracks its head, tail and fill count. To send, a processor reads its peer's descriptor to see if there is room. It fills the slot at the peer's head position with 32-bit word writes, then issues a send command. That command marks the slot as unread, advances the head and raises the receiver's interrupt. The interrupt stays high while the mailbox holds any unread slot. A receiver that does not take interrupts can poll its own descriptor instead. It reads the message out of its slot window and frees the slot with a pop command.

Processor 0 is the boot master. After reset only processor 0 may access the block, and processor 1 is held halted. Processor 0 releases it with a wake command, which raises a run-enable level and a single-cycle wake interrupt.

Top module: `ipc_mailbox_top`

## Requirements
- R1: After reset both mailboxes are empty, with head, tail and count at 0. Both mailbox interrupts, `slave_run` and `wake_irq` are low, and a status read returns 0.
- R2: A bus address is a word address. When its top bit is 1 it selects the slot window: the bits above the low log2(SLOT_WORDS) bits give the slot index and the low bits give the word within the slot. A write in the slot window from processor p stores into the mailbox of the other processor. A read in the slot window returns that word from the reader's own mailbox.
- R3: A slot that holds an unread message cannot be overwritten. A slot-window write aimed at such a slot is dropped and the stored word keeps its value.
- R4: A send command (register 2, bit 0) marks the slot at the peer's head as unread and advances the head by one, wrapping from SLOTS-1 to 0. It also raises the count by one. Each processor's interrupt equals "own count is non-zero".
- R5: A pop command (register 2, bit 1) clears the unread mark of the slot at the tail, advances the tail with wrap-around and lowers the count. Slots are therefore released in the order they were sent. A pop on an empty mailbox changes nothing.
- R6: A send to a mailbox that already holds SLOTS unread messages is refused. Head, tail, count and contents stay unchanged, and bit 26 of the sender's own status is set. That bit stays set until the sender writes a clear command (register 2, bit 2).
- R7: Register 0 returns the processor's own mailbox status and register 1 returns the peer's. The status word has head in bits 7:0, tail in 15:8 and count in 23:16. Bit 24 is set when the mailbox is non-empty and bit 25 when it is full. Bit 26 is the overflow flag, and it is always 0 in the peer view. Read data appears one cycle after the request and reflects the state at the request cycle.
- R8: Until processor 0 writes a wake command (register 2, bit 3), every access from processor 1 is ignored and `slave_run` stays low. The first wake sets `slave_run` for good and pulses `wake_irq` for exactly one cycle. Later wake commands, and any wake command from processor 1, produce no pulse.
- R9: A send into a mailbox and a pop from the same mailbox in the same cycle leave the count unchanged and move both pointers. When the mailbox is full at that cycle, the send is still refused and only the pop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 2 | Per-processor access request, one cycle per access |
| bus_we | input | 2 | Per-processor write enable (1 = write, 0 = read) |
| bus_addr | input | 2 x ADDR_W | Per-processor word address |
| bus_wdata | input | 2 x 32 | Per-processor write data |
| bus_rdata | output | 2 x 32 | Per-processor read data, valid the cycle after a read request |
| mbox_irq | output | 2 | Per-processor interrupt, high while its mailbox is non-empty |
| slave_run | output | 1 | Run enable for processor 1, low until woken |
| wake_irq | output | 1 | One-cycle wake interrupt to processor 1 |

## Verification
The assertions take for granted that SLOTS and SLOT_WORDS are powers of two, so that pointer increments wrap by themselves. They also assume reset is held for at least one clock at start-up. The assertions further assume a processor never puts send and clear in the same command word. The stimulus keeps to this: every command word the bench writes carries one command bit, and concurrent send and pop reach the block only as separate writes on the two ports. Slot indices and word offsets are drawn inside their ranges. Random slot writes are biased toward the peer's head slot, so that both accepted and dropped writes occur.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 8;

    // register indices inside the control region
    localparam logic [1:0] REG_OWN  = 2'd0;
    localparam logic [1:0] REG_PEER = 2'd1;
    localparam logic [1:0] REG_CMD  = 2'd2;

    // command bit positions
    localparam int CMD_SEND  = 0;
    localparam int CMD_POP   = 1;
    localparam int CMD_CLEAR = 2;
    localparam int CMD_WAKE  = 3;

    typedef struct packed {
        logic wake;
        logic clear;
        logic pop;
        logic send;
    } cmd_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_REG,
        RD_SLOT
    } rd_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] head;
        logic [FIELD_W-1:0] tail;
        logic [FIELD_W-1:0] count;
        logic               full;
    } desc_t;

    function automatic logic [WORD_W-1:0] pack_status(desc_t d, logic overflow);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[7:0]   = d.head;
        w[15:8]  = d.tail;
        w[23:16] = d.count;
        w[24]    = (d.count != '0);
        w[25]    = d.full;
        w[26]    = overflow;
        return w;
    endfunction

    function automatic cmd_t decode_cmd(logic [WORD_W-1:0] v);
        cmd_t c;
        c.send  = v[CMD_SEND];
        c.pop   = v[CMD_POP];
        c.clear = v[CMD_CLEAR];
        c.wake  = v[CMD_WAKE];
        return c;
    endfunction

endpackage

// File: rtl/ipc_mbox_queue.sv
module ipc_mbox_queue
    import ipc_mbox_pkg::*;
#(
    parameter int SLOTS      = 16,
    parameter int SLOT_WORDS = 32,
    localparam int SLOT_BITS = $clog2(SLOTS),
    localparam int WORD_BITS = $clog2(SLOT_WORDS),
    localparam int CNT_W     = SLOT_BITS + 1,
    localparam int DEPTH     = SLOTS * SLOT_WORDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SLOT_BITS-1:0] wr_slot,
    input  logic [WORD_BITS-1:0] wr_word,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 push,
    input  logic                 pop,
    input  logic [SLOT_BITS-1:0] rd_slot,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic [WORD_W-1:0]    rd_data,
    output desc_t                desc,
    output logic                 push_refused,
    output logic                 nonempty
);

    logic [SLOT_BITS-1:0] head_q, tail_q;
    logic [CNT_W-1:0]     count_q, count_d;
    logic [SLOTS-1:0]     flag_q;
    logic [WORD_W-1:0]    mem [DEPTH];

    logic full, empty, push_ok, pop_ok, wr_ok;

    assign full    = (count_q == CNT_W'(SLOTS));
    assign empty   = (count_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign wr_ok   = wr_en && !flag_q[wr_slot];

    always_comb begin
        count_d = count_q;
        if (push_ok && !pop_ok)
            count_d = count_q + CNT_W'(1);
        else if (pop_ok && !push_ok)
            count_d = count_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            flag_q  <= '0;
        end else begin
            count_q <= count_d;
            if (push_ok) begin
                flag_q[head_q] <= 1'b1;
                head_q         <= head_q + 1'b1;
            end
            if (pop_ok) begin
                flag_q[tail_q] <= 1'b0;
                tail_q         <= tail_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[{wr_slot, wr_word}] <= wr_data;
        rd_data <= mem[{rd_slot, rd_word}];
    end

    always_comb begin
        desc.head  = FIELD_W'(head_q);
        desc.tail  = FIELD_W'(tail_q);
        desc.count = FIELD_W'(count_q);
        desc.full  = full;
    end

    assign push_refused = push && full;
    assign nonempty     = !empty;

    // R4: unread marks and fill count move together
    a_r4_flags_track_count: assert property (@(posedge clk) disable iff (rst)
        $countones(flag_q) == int'(count_q));

    a_r4_count_limit: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(SLOTS));

    // R6: a refused send leaves the descriptor alone
    a_r6_refused_hold: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ($stable(count_q) && $stable(head_q)));

    // R5: pop on empty is a no-op
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> ((count_q == '0) && $stable(tail_q)));

    // R9: simultaneous accepted push and pop keep the count
    a_r9_both_move: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !full && !empty) |=> $stable(count_q));

endmodule

// File: rtl/ipc_port_ctrl.sv
module ipc_port_ctrl
    import ipc_mbox_pkg::*;
#(
    parameter int SLOTS      = 16,
    parameter int SLOT_WORDS = 32,
    parameter bit IS_MASTER  = 1'b0,
    localparam int SLOT_BITS = $clog2(SLOTS),
    localparam int WORD_BITS = $clog2(SLOT_WORDS),
    localparam int ADDR_W    = 1 + SLOT_BITS + WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  desc_t                own_desc,
    input  desc_t                peer_desc,
    input  logic [WORD_W-1:0]    slot_rd_data,
    input  logic                 tx_refused,
    output logic                 tx_wr_en,
    output logic [SLOT_BITS-1:0] tx_slot,
    output logic [WORD_BITS-1:0] tx_word,
    output logic [WORD_W-1:0]    tx_data,
    output logic                 tx_push,
    output logic                 rx_pop,
    output logic [SLOT_BITS-1:0] rx_rd_slot,
    output logic [WORD_BITS-1:0] rx_rd_word,
    output logic                 wake_cmd
);

    logic       access, in_slot, cmd_hit, clear;
    logic [1:0] reg_idx;
    cmd_t       cmd;
    rd_kind_e   kind_q;
    logic [WORD_W-1:0] cap_q;
    logic       ovf_q;

    assign access  = req && enable;
    assign in_slot = addr[ADDR_W-1];
    assign reg_idx = addr[1:0];
    assign cmd     = decode_cmd(wdata);
    assign cmd_hit = access && we && !in_slot && (reg_idx == REG_CMD);

    assign tx_wr_en   = access && we && in_slot;
    assign tx_slot    = addr[WORD_BITS +: SLOT_BITS];
    assign tx_word    = addr[WORD_BITS-1:0];
    assign tx_data    = wdata;
    assign rx_rd_slot = addr[WORD_BITS +: SLOT_BITS];
    assign rx_rd_word = addr[WORD_BITS-1:0];

    assign tx_push  = cmd_hit && cmd.send;
    assign rx_pop   = cmd_hit && cmd.pop;
    assign clear    = cmd_hit && cmd.clear;
    assign wake_cmd = IS_MASTER && cmd_hit && cmd.wake;

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (tx_refused)
            ovf_q <= 1'b1;
        else if (clear)
            ovf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= RD_NONE;
            cap_q  <= '0;
        end else if (access && !we) begin
            if (in_slot) begin
                kind_q <= RD_SLOT;
                cap_q  <= '0;
            end else begin
                kind_q <= RD_REG;
                case (reg_idx)
                    REG_OWN:  cap_q <= pack_status(own_desc, ovf_q);
                    REG_PEER: cap_q <= pack_status(peer_desc, 1'b0);
                    default:  cap_q <= '0;
                endcase
            end
        end else begin
            kind_q <= RD_NONE;
            cap_q  <= '0;
        end
    end

    assign rdata = (kind_q == RD_SLOT) ? slot_rd_data : cap_q;

    // R6: overflow flag only drops on an explicit clear
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clear) |=> ovf_q);

    // R6: a refused send always leaves the flag set
    a_r6_ovf_on_refuse: assert property (@(posedge clk) disable iff (rst)
        tx_refused |=> ovf_q);

endmodule

// File: rtl/ipc_boot_ctrl.sv
module ipc_boot_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wake_cmd,
    output logic slave_run,
    output logic wake_irq
);

    logic run_q, pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wake_cmd && !run_q;
            if (wake_cmd)
                run_q <= 1'b1;
        end
    end

    assign slave_run = run_q;
    assign wake_irq  = pulse_q;

    // R8: release is permanent until reset
    a_r8_run_stays: assert property (@(posedge clk) disable iff (rst)
        slave_run |=> slave_run);

    // R8: wake interrupt lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq);

    // R8: the pulse coincides with the release
    a_r8_pulse_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(slave_run) |-> wake_irq);

endmodule

// File: rtl/ipc_mailbox_top.sv
module ipc_mailbox_top
    import ipc_mbox_pkg::*;
#(
    parameter int SLOTS      = 16,
    parameter int SLOT_WORDS = 32,
    localparam int SLOT_BITS = $clog2(SLOTS),
    localparam int WORD_BITS = $clog2(SLOT_WORDS),
    localparam int ADDR_W    = 1 + SLOT_BITS + WORD_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             bus_req,
    input  logic [1:0]             bus_we,
    input  logic [1:0][ADDR_W-1:0] bus_addr,
    input  logic [1:0][WORD_W-1:0] bus_wdata,
    output logic [1:0][WORD_W-1:0] bus_rdata,
    output logic [1:0]             mbox_irq,
    output logic                   slave_run,
    output logic                   wake_irq
);

    logic                 tx_wr_en   [2];
    logic [SLOT_BITS-1:0] tx_slot    [2];
    logic [WORD_BITS-1:0] tx_word    [2];
    logic [WORD_W-1:0]    tx_data    [2];
    logic                 tx_push    [2];
    logic                 rx_pop     [2];
    logic [SLOT_BITS-1:0] rx_rd_slot [2];
    logic [WORD_BITS-1:0] rx_rd_word [2];
    logic [WORD_W-1:0]    slot_rd    [2];
    desc_t                desc       [2];
    logic                 refused    [2];
    logic                 nonempty   [2];
    logic                 wake_cmd   [2];
    logic                 run;

    for (genvar p = 0; p < 2; p++) begin : g_side
        // mailbox p belongs to processor p and is filled by the other one
        ipc_mbox_queue #(
            .SLOTS(SLOTS),
            .SLOT_WORDS(SLOT_WORDS)
        ) u_queue (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (tx_wr_en[1-p]),
            .wr_slot     (tx_slot[1-p]),
            .wr_word     (tx_word[1-p]),
            .wr_data     (tx_data[1-p]),
            .push        (tx_push[1-p]),
            .pop         (rx_pop[p]),
            .rd_slot     (rx_rd_slot[p]),
            .rd_word     (rx_rd_word[p]),
            .rd_data     (slot_rd[p]),
            .desc        (desc[p]),
            .push_refused(refused[p]),
            .nonempty    (nonempty[p])
        );

        ipc_port_ctrl #(
            .SLOTS(SLOTS),
            .SLOT_WORDS(SLOT_WORDS),
            .IS_MASTER(p == 0)
        ) u_port (
            .clk         (clk),
            .rst         (rst),
            .enable      ((p == 0) ? 1'b1 : run),
            .req         (bus_req[p]),
            .we          (bus_we[p]),
            .addr        (bus_addr[p]),
            .wdata       (bus_wdata[p]),
            .rdata       (bus_rdata[p]),
            .own_desc    (desc[p]),
            .peer_desc   (desc[1-p]),
            .slot_rd_data(slot_rd[p]),
            .tx_refused  (refused[1-p]),
            .tx_wr_en    (tx_wr_en[p]),
            .tx_slot     (tx_slot[p]),
            .tx_word     (tx_word[p]),
            .tx_data     (tx_data[p]),
            .tx_push     (tx_push[p]),
            .rx_pop      (rx_pop[p]),
            .rx_rd_slot  (rx_rd_slot[p]),
            .rx_rd_word  (rx_rd_word[p]),
            .wake_cmd    (wake_cmd[p])
        );

        assign mbox_irq[p] = nonempty[p];
    end

    ipc_boot_ctrl u_boot (
        .clk      (clk),
        .rst      (rst),
        .wake_cmd (wake_cmd[0] | wake_cmd[1]),
        .slave_run(run),
        .wake_irq (wake_irq)
    );

    assign slave_run = run;

    // R8: a halted processor cannot move its peer's mailbox
    a_r8_halted_no_send: assert property (@(posedge clk) disable iff (rst)
        (!run && !tx_push[0]) |=> $stable(desc[0]));

endmodule

// File: tb/ipc_mailbox_top_test.sv
module ipc_mailbox_top_test;
    import ipc_mbox_pkg::*;

    localparam int SLOTS      = 16;
    localparam int SLOT_WORDS = 32;
    localparam int SB         = $clog2(SLOTS);
    localparam int WB         = $clog2(SLOT_WORDS);
    localparam int AW         = 1 + SB + WB;
    localparam int DEPTH      = SLOTS * SLOT_WORDS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0]         bus_req = '0;
    logic [1:0]         bus_we = '0;
    logic [1:0][AW-1:0] bus_addr = '0;
    logic [1:0][31:0]   bus_wdata = '0;
    logic [1:0][31:0]   bus_rdata;
    logic [1:0]         mbox_irq;
    logic               slave_run, wake_irq;

    always #2 clk = ~clk;

    ipc_mailbox_top #(.SLOTS(SLOTS), .SLOT_WORDS(SLOT_WORDS)) uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mbox_irq(mbox_irq), .slave_run(slave_run), .wake_irq(wake_irq)
    );

    int checks = 0;
    int failures = 0;

    // reference state
    logic [31:0]      m_mem   [2][DEPTH];
    bit               m_valid [2][DEPTH];
    logic [SLOTS-1:0] m_flag  [2];
    int               m_head  [2];
    int               m_tail  [2];
    int               m_cnt   [2];
    logic             m_ovf   [2];
    logic             m_run;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] slot_addr(int s, int w);
        return AW'((1 << (AW-1)) | (s << WB) | w);
    endfunction

    function automatic logic [AW-1:0] reg_addr(int r);
        return AW'(r);
    endfunction

    function automatic logic [31:0] exp_stat(int q, logic ov);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = 8'(m_head[q]);
        w[15:8]  = 8'(m_tail[q]);
        w[23:16] = 8'(m_cnt[q]);
        w[24]    = (m_cnt[q] != 0);
        w[25]    = (m_cnt[q] == SLOTS);
        w[26]    = ov;
        return w;
    endfunction

    function automatic bit live(int p);
        return (p == 0) || m_run;
    endfunction

    task automatic m_write(int p, int s, int w, logic [31:0] d);
        int dst;
        if (!live(p)) return;
        dst = 1 - p;
        if (!m_flag[dst][s]) begin
            m_mem[dst][s*SLOT_WORDS+w]   = d;
            m_valid[dst][s*SLOT_WORDS+w] = 1'b1;
        end
    endtask

    task automatic m_apply(int p, logic [31:0] c);
        int dst;
        if (!live(p)) return;
        dst = 1 - p;
        if (c[CMD_SEND]) begin
            if (m_cnt[dst] == SLOTS) m_ovf[p] = 1'b1;
            else begin
                m_flag[dst][m_head[dst]] = 1'b1;
                m_head[dst] = (m_head[dst] + 1) % SLOTS;
                m_cnt[dst]++;
            end
        end
        if (c[CMD_POP] && m_cnt[p] != 0) begin
            m_flag[p][m_tail[p]] = 1'b0;
            m_tail[p] = (m_tail[p] + 1) % SLOTS;
            m_cnt[p]--;
        end
        if (c[CMD_CLEAR]) m_ovf[p] = 1'b0;
        if (c[CMD_WAKE] && p == 0) m_run = 1'b1;
    endtask

    task automatic bus_wr(int p, logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req[p] = 1'b1; bus_we[p] = 1'b1; bus_addr[p] = a; bus_wdata[p] = d;
        @(negedge clk);
        bus_req[p] = 1'b0; bus_we[p] = 1'b0;
    endtask

    task automatic bus_rd(int p, logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req[p] = 1'b1; bus_we[p] = 1'b0; bus_addr[p] = a;
        @(negedge clk);
        d = bus_rdata[p];
        bus_req[p] = 1'b0;
    endtask

    task automatic do_write(int p, int s, int w, logic [31:0] d);
        bus_wr(p, slot_addr(s, w), d);
        m_write(p, s, w, d);
    endtask

    task automatic do_cmd(int p, logic [31:0] c);
        bus_wr(p, reg_addr(2), c);
        m_apply(p, c);
    endtask

    task automatic chk_own(int p, string tag);
        logic [31:0] v;
        bus_rd(p, reg_addr(0), v);
        chk(tag, v, live(p) ? exp_stat(p, m_ovf[p]) : 32'h0);
    endtask

    task automatic chk_peer(int p, string tag);
        logic [31:0] v;
        bus_rd(p, reg_addr(1), v);
        chk(tag, v, live(p) ? exp_stat(1 - p, 1'b0) : 32'h0);
    endtask

    task automatic chk_slot(int p, int s, int w, string tag);
        logic [31:0] v;
        if (!m_valid[p][s*SLOT_WORDS+w]) return;
        bus_rd(p, slot_addr(s, w), v);
        chk(tag, v, m_mem[p][s*SLOT_WORDS+w]);
    endtask

    task automatic chk_irq(string tag);
        chk(tag, {30'b0, mbox_irq}, {30'b0, m_cnt[1] != 0, m_cnt[0] != 0});
    endtask

    // R9 stimulus: send from port 0 and pop on port 1 in one cycle
    task automatic dual_send_pop();
        @(negedge clk);
        bus_req = 2'b11; bus_we = 2'b11;
        bus_addr[0] = reg_addr(2); bus_wdata[0] = 32'(1 << CMD_SEND);
        bus_addr[1] = reg_addr(2); bus_wdata[1] = 32'(1 << CMD_POP);
        @(negedge clk);
        bus_req = 2'b00; bus_we = 2'b00;
        m_apply(0, 32'(1 << CMD_SEND));
        m_apply(1, 32'(1 << CMD_POP));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        for (int q = 0; q < 2; q++) begin
            m_flag[q] = '0; m_head[q] = 0; m_tail[q] = 0; m_cnt[q] = 0; m_ovf[q] = 1'b0;
            for (int i = 0; i < DEPTH; i++) m_valid[q][i] = 1'b0;
        end
        m_run = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {30'b0, mbox_irq}, 32'h0);
        chk("R1 slave_run", {31'b0, slave_run}, 32'h0);
        chk("R1 wake_irq", {31'b0, wake_irq}, 32'h0);
        chk_own(0, "R1 own status");
        chk_peer(0, "R1 peer status");

        // R8 processor 1 held: its accesses do nothing
        do_write(1, 0, 0, 32'hDEAD_0001);
        do_cmd(1, 32'(1 << CMD_SEND));
        chk("R8 held send irq", {30'b0, mbox_irq}, 32'h0);
        chk_own(0, "R8 held send status");
        do_cmd(1, 32'(1 << CMD_WAKE));
        chk("R8 self wake ignored", {31'b0, slave_run}, 32'h0);

        // R8 release
        do_cmd(0, 32'(1 << CMD_WAKE));
        chk("R8 wake pulse", {31'b0, wake_irq}, 32'h1);
        chk("R8 run", {31'b0, slave_run}, 32'h1);
        @(negedge clk);
        chk("R8 pulse width", {31'b0, wake_irq}, 32'h0);
        do_cmd(0, 32'(1 << CMD_WAKE));
        chk("R8 second wake no pulse", {31'b0, wake_irq}, 32'h0);

        // R2/R4 first message to processor 1
        for (int w = 0; w < 4; w++) do_write(0, 0, w, 32'hA5A5_0000 + 32'(w));
        do_cmd(0, 32'(1 << CMD_SEND));
        chk_irq("R4 irq after send");
        bus_rd(1, reg_addr(0), v);
        chk("R7 status layout", v, 32'h0101_0001);
        chk_peer(0, "R7 peer view");
        for (int w = 0; w < 4; w++) chk_slot(1, 0, w, "R2 slot data");

        // R3 overwrite of unread slot dropped
        do_write(0, 0, 1, 32'hBAD0_BAD0);
        chk_slot(1, 0, 1, "R3 unread slot kept");

        // R4 fill to wrap, R6 overflow
        for (int i = 1; i < SLOTS; i++) do_cmd(0, 32'(1 << CMD_SEND));
        bus_rd(1, reg_addr(0), v);
        chk("R4 head wrap full", v, 32'h0310_0000);
        do_cmd(0, 32'(1 << CMD_SEND));
        bus_rd(0, reg_addr(0), v);
        chk("R6 overflow flag", v, 32'h0400_0000);
        chk_own(1, "R6 full unchanged");
        do_cmd(0, 32'(1 << CMD_SEND));
        chk_own(0, "R6 flag sticky");
        do_cmd(0, 32'(1 << CMD_CLEAR));
        chk_own(0, "R6 flag cleared");

        // R9 concurrent send and pop, full then partly filled
        dual_send_pop();
        chk_own(1, "R9 full send refused pop taken");
        chk_own(0, "R9 refusal flagged");
        do_cmd(0, 32'(1 << CMD_CLEAR));
        dual_send_pop();
        chk_own(1, "R9 both pointers move");

        // R5 drain in order, then pop on empty
        while (m_cnt[1] != 0) begin
            do_cmd(1, 32'(1 << CMD_POP));
            chk_own(1, "R5 pop order");
        end
        chk_irq("R5 irq low when drained");
        do_cmd(1, 32'(1 << CMD_POP));
        chk_own(1, "R5 empty pop no effect");
        do_write(0, 0, 2, 32'h600D_0002);
        chk_slot(1, 0, 2, "R3 freed slot writable");

        // constrained random phase
        for (int it = 0; it < 600; it++) begin
            int p, op, s, w;
            p  = $urandom_range(0, 1);
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: begin
                    s = ($urandom_range(0, 2) != 0) ? m_head[1-p] : $urandom_range(0, SLOTS-1);
                    w = $urandom_range(0, 3);
                    do_write(p, s, w, $urandom);
                end
                3, 4: do_cmd(p, 32'(1 << CMD_SEND));
                5:    do_cmd(p, 32'(1 << CMD_POP));
                6:    chk_own(p, "R7 random own");
                7:    chk_peer(p, "R7 random peer");
                8:    chk_slot(p, m_tail[p], $urandom_range(0, 3), "R2 random slot read");
                default: do_cmd(p, 32'(1 << CMD_CLEAR));
            endcase
            chk_irq("R4 random irq");
        end
        chk_own(0, "R6 final own 0");
        chk_own(1, "R6 final own 1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule